// File: doc/BRIEF.md
# Section Parity Error Monitor

This block watches a byte-wide SONET receive stream, exactly as it arrives and before any descrambling. It keeps an 8-lane even parity over every accepted byte of a frame. Lane i collects bit i of each byte. When the next frame starts, the finished code is held. It is then compared against the check byte that the new frame carries in the first position of its second row.

Every bit that differs counts as one error. The errors are added into a saturating counter. A processor-side read strobe copies that counter into a holding register and restarts the count in the same clock. The block takes a single-rate (STS-1) or triple-rate concatenated (STS-3c) layout select, and an out-of-frame flag that suppresses comparisons. Framing, descrambling and the bus that carries the read strobe are all outside this block.

Top module: `sbip_monitor`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `cmp_valid` is 0 and `err_snap` is 0.
- R2: Bit i of the code for a frame is the XOR of bit i of every byte accepted in that frame, including the frame's own check byte. The bytes are taken as received.
- R3: The check byte is the accepted byte whose index from the start-of-frame byte (index 0) equals the row width. The row width is `COLS_UNIT` when `fmt_sts3c`=0 and 3*`COLS_UNIT` when `fmt_sts3c`=1. A frame is `ROWS` rows long.
- R4: One cycle after the check byte is accepted, `cmp_valid` pulses for one cycle. At the same time `cmp_errs` gives the number of bit positions (0 to 8) in which the check byte differs from the previous frame's code.
- R5: The first frame after reset has no previous code, so its check byte produces no comparison.
- R6: When `oof`=1 on the cycle the check byte is accepted, no comparison is made and the counter does not change.
- R7: The error counter is `CNT_W` bits wide. It saturates at 2^`CNT_W`-1 and never wraps.
- R8: On a cycle with `rd_strobe`=1, the counter value moves into `err_snap` and the counter restarts from zero. `err_snap` shows the value one cycle later. Errors that are added on that same cycle go into the new period.
- R9: Cycles with `rx_valid`=0 do not change the parity or the byte position, whatever `rx_data` and `rx_sof` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte, still scrambled |
| rx_valid | input | 1 | `rx_data` carries a byte this cycle |
| rx_sof | input | 1 | The valid byte is the first byte of a frame |
| fmt_sts3c | input | 1 | 1 selects the triple-rate layout, 0 the single-rate layout |
| oof | input | 1 | Out-of-frame flag; suppresses comparisons |
| rd_strobe | input | 1 | Snapshot the counter and clear it |
| cmp_valid | output | 1 | A comparison result is present |
| cmp_errs | output | 4 | Mismatching bit count of that comparison |
| err_snap | output | CNT_W | Counter value captured by the last read |

## Verification
The bench builds the block with `COLS_UNIT`=4 and `CNT_W`=6. This gives 36-byte and 108-byte frames, so dozens of frames in both layouts fit in a short run. A counter that tops out at 63 can be driven into saturation with only nine fully-errored frames. The check byte is placed at the other layout's position in neither case, so a wrong position choice shows up as wrong error counts. Idle gaps, a frame held out-of-frame, and a read that lands on a comparison cycle cover the suppression and period-boundary cases.

// File: rtl/sbip_pkg.sv
package sbip_pkg;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_TRIPLE = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic       valid;
        logic [3:0] errs;
    } cmp_res_t;

    function automatic logic [3:0] popcount8(input logic [7:0] v);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/sbip_pos_tracker.sv
module sbip_pos_tracker
    import sbip_pkg::*;
#(
    parameter int COLS_UNIT = 90,
    parameter int ROWS      = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  frame_fmt_e fmt,
    output logic       check_hit
);
    localparam int MAX_BYTES = 3 * ROWS * COLS_UNIT;
    localparam int POS_W     = $clog2(MAX_BYTES + 1);
    localparam logic [POS_W-1:0] CHK_SINGLE = POS_W'(COLS_UNIT);
    localparam logic [POS_W-1:0] CHK_TRIPLE = POS_W'(3 * COLS_UNIT);
    localparam logic [POS_W-1:0] POS_CAP    = POS_W'(MAX_BYTES);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_idx;
    logic [POS_W-1:0] chk_idx;

    always_comb begin
        cur_idx = rx_sof ? '0 : pos_q;
        chk_idx = (fmt == FMT_TRIPLE) ? CHK_TRIPLE : CHK_SINGLE;
        check_hit = rx_valid && (cur_idx == chk_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (rx_valid) begin
            pos_q <= (cur_idx == POS_CAP) ? cur_idx : cur_idx + 1'b1;
        end
    end

    AST_CHECK_NOT_SOF: assert property (@(posedge clk) disable iff (rst)
        check_hit |-> !rx_sof); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> pos_q == $past(pos_q)); // R9

endmodule

// File: rtl/sbip_parity_acc.sv
module sbip_parity_acc
    import sbip_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [LANES-1:0] rx_data,
    output logic [LANES-1:0] prev_code,
    output logic             have_prev
);
    logic [LANES-1:0] acc_q;
    logic [LANES-1:0] prev_q;
    logic             started_q;
    logic             have_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i]  <= 1'b0;
                prev_q[i] <= 1'b0;
            end else if (rx_valid) begin
                if (rx_sof) begin
                    prev_q[i] <= acc_q[i];
                    acc_q[i]  <= rx_data[i];
                end else begin
                    acc_q[i]  <= acc_q[i] ^ rx_data[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            have_q    <= 1'b0;
        end else if (rx_valid && rx_sof) begin
            started_q <= 1'b1;
            have_q    <= started_q;
        end
    end

    assign prev_code = prev_q;
    assign have_prev = have_q;

    AST_FIRST_NONE: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof && !started_q) |=> !have_q); // R5

endmodule

// File: rtl/sbip_err_counter.sv
module sbip_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_valid,
    input  logic [3:0]       add_errs,
    input  logic             rd_strobe,
    output logic [CNT_W-1:0] snap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   add_ext;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        base    = rd_strobe ? '0 : cnt_q;
        add_ext = add_valid ? {{(CNT_W-3){1'b0}}, add_errs} : '0;
        sum     = {1'b0, base} + add_ext;
        cnt_d   = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            snap_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (rd_strobe) begin
                snap_q <= cnt_q;
            end
        end
    end

    assign snap = snap_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> cnt_q >= $past(cnt_q)); // R7
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !rd_strobe) |=> cnt_q == CNT_MAX); // R7
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !add_valid) |=> cnt_q == '0); // R8

endmodule

// File: rtl/sbip_monitor.sv
module sbip_monitor
    import sbip_pkg::*;
#(
    parameter int COLS_UNIT = 90,
    parameter int ROWS      = 9,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             fmt_sts3c,
    input  logic             oof,
    input  logic             rd_strobe,
    output logic             cmp_valid,
    output logic [3:0]       cmp_errs,
    output logic [CNT_W-1:0] err_snap
);
    frame_fmt_e fmt;
    logic       check_hit;
    logic [7:0] prev_code;
    logic       have_prev;
    cmp_res_t   cmp_d;
    cmp_res_t   cmp_q;

    assign fmt = frame_fmt_e'(fmt_sts3c);

    sbip_pos_tracker #(.COLS_UNIT(COLS_UNIT), .ROWS(ROWS)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .fmt      (fmt),
        .check_hit(check_hit)
    );

    sbip_parity_acc #(.LANES(8)) u_par (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_data  (rx_data),
        .prev_code(prev_code),
        .have_prev(have_prev)
    );

    always_comb begin
        cmp_d.valid = check_hit && have_prev && !oof;
        cmp_d.errs  = popcount8(rx_data ^ prev_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    sbip_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .add_valid(cmp_q.valid),
        .add_errs (cmp_q.errs),
        .rd_strobe(rd_strobe),
        .snap     (err_snap)
    );

    assign cmp_valid = cmp_q.valid;
    assign cmp_errs  = cmp_q.errs;

    AST_OOF_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        oof |=> !cmp_valid); // R6
    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |-> cmp_errs <= 4'd8); // R4
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> !cmp_valid); // R4

endmodule

// File: tb/sbip_monitor_bench.sv
module sbip_monitor_bench;
    localparam int COLS  = 4;
    localparam int ROWS  = 9;
    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic rx_valid = 1'b0, rx_sof = 1'b0, fmt_sts3c = 1'b0, oof = 1'b0, rd_strobe = 1'b0;
    logic cmp_valid;
    logic [3:0] cmp_errs;
    logic [CNT_W-1:0] err_snap;

    int checks = 0, errors = 0, cycles = 0, cmp_seen = 0;
    logic [7:0] drv_prev = 8'h00;

    // behavioural reference state
    int m_pos = 0, m_cnt = 0, m_snap = 0, m_ce = 0;
    bit m_cv = 0, m_have = 0, m_started = 0;
    logic [7:0] m_acc = 0, m_prev = 0;

    always #5 clk = ~clk;

    sbip_monitor #(.COLS_UNIT(COLS), .ROWS(ROWS), .CNT_W(CNT_W)) u_sbip_monitor (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .fmt_sts3c(fmt_sts3c), .oof(oof), .rd_strobe(rd_strobe),
        .cmp_valid(cmp_valid), .cmp_errs(cmp_errs), .err_snap(err_snap)
    );

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, advanced on every clock edge
    always @(posedge clk) begin
        int add, idx;
        if (rst) begin
            m_pos = 0; m_cnt = 0; m_snap = 0; m_cv = 0; m_ce = 0;
            m_have = 0; m_started = 0; m_acc = 0; m_prev = 0;
        end else begin
            add = m_cv ? m_ce : 0;
            if (rd_strobe) begin
                m_snap = m_cnt;
                m_cnt = (add > CMAX) ? CMAX : add;
            end else begin
                m_cnt = (m_cnt + add > CMAX) ? CMAX : m_cnt + add;
            end
            m_cv = 0;
            if (rx_valid) begin
                idx = rx_sof ? 0 : m_pos;
                if (idx == (fmt_sts3c ? 3 * COLS : COLS) && m_have && !oof) begin
                    m_cv = 1;
                    m_ce = ones(rx_data ^ m_prev);
                end
                if (rx_sof) begin
                    m_prev = m_acc; m_have = m_started; m_acc = rx_data; m_started = 1;
                end else begin
                    m_acc = m_acc ^ rx_data;
                end
                m_pos = idx + 1;
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(cmp_valid == m_cv, "R4 cmp_valid", int'(cmp_valid), int'(m_cv));
            if (m_cv) begin
                cmp_seen++;
                check(int'(cmp_errs) == m_ce, "R4 cmp_errs", int'(cmp_errs), m_ce);
            end
            check(int'(err_snap) == m_snap, "R8 err_snap", int'(err_snap), m_snap);
        end
        if (cycles > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send_frame(input bit sts3, input logic [7:0] mask, input bit hold_oof,
                              input bit gaps, input bit rd_after);
        int len, chk;
        logic [7:0] par, b;
        len = sts3 ? 3 * ROWS * COLS : ROWS * COLS;
        chk = sts3 ? 3 * COLS : COLS;
        par = 8'h00;
        for (int k = 0; k < len; k++) begin
            b = 8'($urandom);
            if (k == chk) b = drv_prev ^ mask;
            if (gaps && (k % 5 == 2)) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b1; rx_data = 8'($urandom); rd_strobe = 1'b0;
            end
            @(negedge clk);
            fmt_sts3c = sts3; oof = hold_oof;
            rx_valid = 1'b1; rx_sof = (k == 0); rx_data = b;
            rd_strobe = rd_after && (k == chk + 1);
            par = par ^ b;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rd_strobe = 1'b0; oof = 1'b0;
        drv_prev = par;
    endtask

    task automatic do_read(output int val);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        val = int'(err_snap);
    endtask

    initial begin
        int v, seen0;
        repeat (3) @(negedge clk);
        check(cmp_valid == 1'b0, "R1 cmp_valid in reset", int'(cmp_valid), 0);
        check(err_snap == '0, "R1 err_snap in reset", int'(err_snap), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmp_valid == 1'b0 && err_snap == '0, "R1 after release", int'(err_snap), 0);

        // R2 R5: single-rate frames; first frame produces no comparison
        send_frame(0, 8'h55, 0, 0, 0);
        check(cmp_seen == 0, "R5 first frame compared", cmp_seen, 0);
        send_frame(0, 8'h00, 0, 0, 0);
        send_frame(0, 8'h01, 0, 0, 0);
        send_frame(0, 8'hFF, 0, 0, 0);
        check(cmp_seen == 3, "R5 comparison count", cmp_seen, 3);
        do_read(v);
        check(v == 9, "R2 single-rate total", v, 9);

        // R3: triple-rate layout moves the check byte
        send_frame(1, 8'h07, 0, 0, 0);
        send_frame(1, 8'h80, 0, 0, 0);
        do_read(v);
        check(v == 4, "R3 triple-rate total", v, 4);

        // R6: out-of-frame suppresses the comparison
        seen0 = cmp_seen;
        send_frame(0, 8'hFF, 1, 0, 0);
        check(cmp_seen == seen0, "R6 comparison under oof", cmp_seen, seen0);
        send_frame(0, 8'h00, 0, 0, 0);
        do_read(v);
        check(v == 0, "R6 counter after oof frame", v, 0);

        // R9: idle cycles with garbage are ignored
        send_frame(0, 8'h0F, 0, 1, 0);
        do_read(v);
        check(v == 4, "R9 total with idle gaps", v, 4);

        // R8: read on the cycle errors are added
        send_frame(0, 8'h03, 0, 0, 1);
        check(int'(err_snap) == 0, "R8 snapshot taken before add", int'(err_snap), 0);
        do_read(v);
        check(v == 2, "R8 errors moved to new period", v, 2);

        // R7: saturation
        for (int f = 0; f < 9; f++) send_frame(0, 8'hFF, 0, 0, 0);
        do_read(v);
        check(v == CMAX, "R7 saturated total", v, CMAX);
        do_read(v);
        check(v == 0, "R8 cleared after read", v, 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule